// File: doc/BRIEF.md
# Brightness Level to PWM Duty Converter

This block turns an 8-bit brightness setting into the 16-bit active-duty count of a backlight PWM whose period is programmable. The level is first stretched by 256/255 into an unsigned fixed-point value with one integer bit and sixteen fraction bits. That value is then scaled by the active period and rounded back to 16 bits. The forward path is a single registered stage. A request on `fwd_valid` produces `duty` one cycle later, marked by a one-cycle `duty_valid`.

The block also runs the inverse conversion. It takes a duty count currently in use and returns a 16-bit normalised level, kept as 17 bits so that a carry from rounding is not lost. This path needs a wide division, which a sequential restoring divider performs one quotient bit per cycle. A pulse on `rb_start` while the path is idle launches a conversion. `rb_busy` stays high until the result is presented with a one-cycle `rb_done`.

In both directions the period field is qualified by a 4-bit width code, in which the value 0 stands for sixteen bits.

Top module: `bl_duty_conv`

## Requirements
- R1: `duty` and `duty_valid` update on the clock edge that samples `fwd_valid` high. `duty_valid` is high in exactly the cycles that follow a cycle with `fwd_valid` high.
- R2: The level is widened to U1.16 as floor(level × 0x10101 / 256), plus bit 7 of level × 0x10101. For example, level 0xEF becomes 0xEFF0, and with period 0x24 and width code 6 it yields duty 0x86F7.
- R3: A width code of 0 selects a 16-bit period width. Any other code n selects n bits.
- R4: Period bits at or above the selected width are ignored by both paths.
- R5: The forward duty is the 16-bit truncation of (U1.16 level × masked period) shifted right by the width, plus bit (width − 1) of that product.
- R6: Level 0 gives duty 0. Level 255 gives the masked period shifted left by (16 − width).
- R7: `duty` keeps its value in every cycle in which `duty_valid` is low.
- R8: On readback with `frac_en` low, the duty is ANDed with the width mask shifted left by (16 − width). With `frac_en` high, all 16 duty bits are used.
- R9: On readback, a masked period of 0 is replaced by 0xFFFF.
- R10: The readback result is computed in four steps. First, q = (duty << (width + 1)) / period. Second, h = (q + 1) >> 1. Third, m = h × period. The result is (m >> width) plus bit (width − 1) of m.
- R11: `rb_start` is accepted only while `rb_busy` is low, and a start seen while busy is ignored. After an accepted start, `rb_busy` stays high for 34 cycles. `rb_level` then changes and `rb_done` pulses for one cycle, 34 edges after the accepting edge.
- R12: After reset, `duty`, `duty_valid`, `rb_busy`, `rb_done` and `rb_level` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwd_valid | input | 1 | Request a forward conversion of the present inputs |
| level | input | 8 | Brightness level |
| period | input | 16 | PWM period field |
| period_bits | input | 4 | Period width code, 0 means 16 |
| duty_valid | output | 1 | Forward result updated this cycle |
| duty | output | 16 | Forward active-duty count |
| rb_start | input | 1 | Launch a readback conversion |
| duty_now | input | 16 | Duty count to be converted back |
| frac_en | input | 1 | Use all duty bits on readback |
| rb_busy | output | 1 | Readback in progress |
| rb_done | output | 1 | Readback result updated this cycle |
| rb_level | output | 17 | Normalised readback level |

## Verification
The bench targets the arithmetic edges where a wrong design gives values that look reasonable but are off:
- **Width code 0.** A design that decoded it literally would mask the period to nothing and return zero duty.
- **Period garbage above the width.** Leaving these bits unmasked inflates the product.
- **Rounding bits.** Taking the wrong rounding bit, or dropping it, shifts results by one count.
- **Zero-period substitution.** Without it the divider would produce an all-ones quotient.
- **Fractional flag.** If the flag is ignored, the low duty bits either leak into or drop out of the readback.

A second `rb_start` is injected in the middle of a conversion. A divider that restarts on it would deliver a late result or the wrong one.

// File: rtl/bl_duty_pkg.sv
package bl_duty_pkg;
  localparam int LVL_W   = 8;
  localparam int DUTY_W  = 16;
  localparam int CNT_W   = 4;
  localparam int NB_W    = $clog2(DUTY_W + 1);
  localparam int WIDE_W  = 3 * LVL_W;
  localparam int U_W     = DUTY_W + 1;
  localparam int PROD_W  = U_W + DUTY_W;
  localparam int DIVN_W  = 2 * DUTY_W + 1;
  localparam int HALF_W  = DIVN_W + 1;
  localparam int M_W     = HALF_W + DUTY_W;
  localparam int RB_W    = DUTY_W + 1;
  localparam int RB_LAT  = DIVN_W + 1;
  localparam logic [WIDE_W-1:0] STRETCH_K = WIDE_W'(24'h010101);

  // Decode the width code: zero selects the full duty width.
  function automatic logic [NB_W-1:0] eff_bits(input logic [CNT_W-1:0] code);
    return (code == '0) ? NB_W'(DUTY_W) : NB_W'(code);
  endfunction

  // Mask with the low n bits set.
  function automatic logic [DUTY_W-1:0] width_mask(input logic [NB_W-1:0] n);
    logic [DUTY_W:0] t;
    t = ((DUTY_W+1)'(1) << n) - (DUTY_W+1)'(1);
    return t[DUTY_W-1:0];
  endfunction

  // Level to U1.16 with the 256/255 stretch and half-up rounding.
  function automatic logic [U_W-1:0] stretch_level(input logic [LVL_W-1:0] lv);
    logic [WIDE_W-1:0] w;
    w = WIDE_W'(lv) * STRETCH_K;
    return U_W'(w >> LVL_W) + U_W'((w >> (LVL_W - 1)) & WIDE_W'(1));
  endfunction

  function automatic logic [DUTY_W-1:0] fwd_duty(input logic [LVL_W-1:0] lv,
                                                 input logic [DUTY_W-1:0] per,
                                                 input logic [CNT_W-1:0] code);
    logic [NB_W-1:0]   n;
    logic [DUTY_W-1:0] p;
    logic [PROD_W-1:0] prod;
    n    = eff_bits(code);
    p    = per & width_mask(n);
    prod = PROD_W'(stretch_level(lv)) * PROD_W'(p);
    return DUTY_W'(prod >> n) + DUTY_W'((prod >> (n - NB_W'(1))) & PROD_W'(1));
  endfunction

  function automatic logic [DUTY_W-1:0] rb_divisor(input logic [DUTY_W-1:0] per,
                                                   input logic [NB_W-1:0] n);
    logic [DUTY_W-1:0] p;
    p = per & width_mask(n);
    return (p == '0) ? '1 : p;
  endfunction

  function automatic logic [DIVN_W-1:0] rb_dividend(input logic [DUTY_W-1:0] d,
                                                    input logic frac,
                                                    input logic [NB_W-1:0] n);
    logic [DUTY_W-1:0] dm;
    dm = frac ? d : (d & (width_mask(n) << (NB_W'(DUTY_W) - n)));
    return DIVN_W'(dm) << (n + NB_W'(1));
  endfunction

  // Halve with rounding, rescale by the period, round back by n bits.
  function automatic logic [RB_W-1:0] rb_finish(input logic [DIVN_W-1:0] q,
                                                input logic [DUTY_W-1:0] p,
                                                input logic [NB_W-1:0] n);
    logic [HALF_W-1:0] h;
    logic [M_W-1:0]    m;
    h = (HALF_W'(q) + HALF_W'(1)) >> 1;
    m = M_W'(h) * M_W'(p);
    return RB_W'(m >> n) + RB_W'((m >> (n - NB_W'(1))) & M_W'(1));
  endfunction
endpackage

// File: rtl/bl_fwd_stage.sv
module bl_fwd_stage
  import bl_duty_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [LVL_W-1:0]  level,
  input  logic [DUTY_W-1:0] period,
  input  logic [CNT_W-1:0]  code,
  output logic              out_valid,
  output logic [DUTY_W-1:0] out_duty
);
  logic [DUTY_W-1:0] duty_next;

  assign duty_next = fwd_duty(level, period, code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_duty  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_duty <= duty_next;
    end
  end
endmodule

// File: rtl/bl_rb_operands.sv
module bl_rb_operands
  import bl_duty_pkg::*;
(
  input  logic [DUTY_W-1:0] duty_in,
  input  logic [DUTY_W-1:0] period,
  input  logic [CNT_W-1:0]  code,
  input  logic              frac,
  output logic [NB_W-1:0]   n_bits,
  output logic [DIVN_W-1:0] dividend,
  output logic [DUTY_W-1:0] divisor
);
  always_comb begin
    n_bits   = eff_bits(code);
    divisor  = rb_divisor(period, n_bits);
    dividend = rb_dividend(duty_in, frac, n_bits);
  end
endmodule

// File: rtl/bl_restoring_div.sv
module bl_restoring_div #(
  parameter int NUM_W = 33,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CW-1:0]    cnt_q;
  logic [DEN_W:0]   trial;
  logic             take;

  assign trial = {rem_q, quot[NUM_W-1]};
  assign take  = trial >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      quot  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          quot  <= num;
          den_q <= den;
          rem_q <= '0;
          cnt_q <= CW'(NUM_W);
          busy  <= 1'b1;
        end
      end else begin
        rem_q <= take ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        quot  <= {quot[NUM_W-2:0], take};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bl_duty_conv.sv
module bl_duty_conv
  import bl_duty_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_valid,
  input  logic [LVL_W-1:0]  level,
  input  logic [DUTY_W-1:0] period,
  input  logic [CNT_W-1:0]  period_bits,
  output logic              duty_valid,
  output logic [DUTY_W-1:0] duty,
  input  logic              rb_start,
  input  logic [DUTY_W-1:0] duty_now,
  input  logic              frac_en,
  output logic              rb_busy,
  output logic              rb_done,
  output logic [RB_W-1:0]   rb_level
);
  logic [NB_W-1:0]   op_n;
  logic [DIVN_W-1:0] op_num;
  logic [DUTY_W-1:0] op_den;
  logic              rb_accept;
  logic              div_busy;
  logic              div_done;
  logic [DIVN_W-1:0] div_quot;
  logic [NB_W-1:0]   hold_n;
  logic [DUTY_W-1:0] hold_den;

  bl_fwd_stage u_fwd (
    .clk(clk), .rst_n(rst_n), .fire(fwd_valid), .level(level),
    .period(period), .code(period_bits),
    .out_valid(duty_valid), .out_duty(duty)
  );

  bl_rb_operands u_ops (
    .duty_in(duty_now), .period(period), .code(period_bits), .frac(frac_en),
    .n_bits(op_n), .dividend(op_num), .divisor(op_den)
  );

  assign rb_busy   = div_busy | div_done;
  assign rb_accept = rb_start & ~rb_busy;

  bl_restoring_div #(.NUM_W(DIVN_W), .DEN_W(DUTY_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(rb_accept), .num(op_num), .den(op_den),
    .busy(div_busy), .done(div_done), .quot(div_quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_n   <= '0;
      hold_den <= '0;
      rb_done  <= 1'b0;
      rb_level <= '0;
    end else begin
      rb_done <= div_done;
      if (rb_accept) begin
        hold_n   <= op_n;
        hold_den <= op_den;
      end
      if (div_done) rb_level <= rb_finish(div_quot, hold_den, hold_n);
    end
  end
endmodule

// File: rtl/bl_duty_conv_chk.sv
module bl_duty_conv_chk
  import bl_duty_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fwd_valid,
  input logic [LVL_W-1:0]  level,
  input logic              duty_valid,
  input logic [DUTY_W-1:0] duty,
  input logic              rb_start,
  input logic              rb_busy,
  input logic              rb_done,
  input logic [RB_W-1:0]   rb_level,
  input logic              div_busy,
  input logic              div_done
);
  logic [7:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (rb_busy) busy_run <= busy_run + 8'd1;
    else busy_run <= '0;
  end

  // R1
  fwd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |=> duty_valid);
  // R1
  fwd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_valid |=> !duty_valid);
  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_valid |-> $stable(duty));
  // R6
  zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && level == '0) |=> duty == '0);
  // R11
  rb_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_start && !rb_busy) |=> rb_busy);
  // R11
  rb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_done |=> !rb_done);
  // R11
  rb_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_done |-> busy_run == 8'(RB_LAT));
  // R11
  rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_done |-> $stable(rb_level));
  // R11
  rb_idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_done |-> !rb_busy);
  // R11
  div_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_busy && div_done));
endmodule

bind bl_duty_conv bl_duty_conv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fwd_valid(fwd_valid), .level(level),
  .duty_valid(duty_valid), .duty(duty), .rb_start(rb_start),
  .rb_busy(rb_busy), .rb_done(rb_done), .rb_level(rb_level),
  .div_busy(div_busy), .div_done(div_done)
);

// File: tb/bl_duty_conv_tb.sv
`timescale 1ns/1ps
module bl_duty_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fwd_valid = 1'b0;
  logic [7:0]  level = '0;
  logic [15:0] period = '0;
  logic [3:0]  period_bits = '0;
  logic        duty_valid;
  logic [15:0] duty;
  logic        rb_start = 1'b0;
  logic [15:0] duty_now = '0;
  logic        frac_en = 1'b0;
  logic        rb_busy;
  logic        rb_done;
  logic [16:0] rb_level;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bl_duty_conv u_dut (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint nb(input int code);
    return (code == 0) ? 16 : code;
  endfunction

  function automatic longint m_duty(input longint lv, input longint per, input int code);
    longint n, p, u, prod;
    n = nb(code);
    p = per % (64'd1 << n);
    u = (lv * 65793 + 128) / 256;
    prod = u * p;
    return ((prod + (64'd1 << (n - 1))) >> n) % 65536;
  endfunction

  function automatic longint m_rb(input longint d, input longint per, input int code, input bit frac);
    longint n, p, dm, q, h, m;
    n = nb(code);
    p = per % (64'd1 << n);
    if (p == 0) p = 65535;
    dm = frac ? d : (d & ((((64'd1 << n) - 1) << (16 - n)) & 16'hFFFF));
    q = (dm << (n + 1)) / p;
    h = (q + 1) / 2;
    m = h * p;
    return ((m + (64'd1 << (n - 1))) >> n) % 131072;
  endfunction

  task automatic fwd(input string req, input int lv, input int per, input int code);
    @(negedge clk);
    level = 8'(lv); period = 16'(per); period_bits = 4'(code); fwd_valid = 1'b1;
    @(negedge clk);
    fwd_valid = 1'b0;
    chk({req, " duty_valid"}, longint'(duty_valid), 1);
    chk(req, longint'(duty), m_duty(lv, per, code));
  endtask

  task automatic rb(input string req, input int d, input int per, input int code,
                    input bit frac, input bit inject);
    int cyc;
    longint exp;
    exp = m_rb(d, per, code, frac);
    @(negedge clk);
    duty_now = 16'(d); period = 16'(per); period_bits = 4'(code); frac_en = frac;
    rb_start = 1'b1;
    @(negedge clk);
    rb_start = 1'b0;
    cyc = 0;
    while (!rb_done && cyc < 100) begin
      if (inject && cyc == 5) begin
        duty_now = 16'hFFFF; period = 16'h0003; period_bits = 4'd2; rb_start = 1'b1;
      end else begin
        rb_start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    rb_start = 1'b0;
    chk({req, " latency"}, cyc, 34);
    chk(req, longint'(rb_level), exp);
    if (inject) begin
      cyc = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (rb_done || rb_busy) cyc++;
      end
      chk("R11 ignored start spawned no work", cyc, 0);
      chk("R11 level kept after ignored start", longint'(rb_level), exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 duty", longint'(duty), 0);
    chk("R12 duty_valid", longint'(duty_valid), 0);
    chk("R12 rb_busy", longint'(rb_busy), 0);
    chk("R12 rb_done", longint'(rb_done), 0);
    chk("R12 rb_level", longint'(rb_level), 0);
    rst_n = 1'b1;

    fwd("R2 example", 8'hEF, 16'h0024, 6);
    chk("R2 literal 0x86F7", longint'(duty), 16'h86F7);
    @(negedge clk);
    chk("R1 duty_valid single cycle", longint'(duty_valid), 0);
    // R7: inputs move without a request
    level = 8'h11; period = 16'h7777; period_bits = 4'd3;
    repeat (3) @(negedge clk);
    chk("R7 duty held", longint'(duty), 16'h86F7);
    fwd("R4 upper period bits", 8'hEF, 16'hFFE4, 6);
    chk("R4 literal", longint'(duty), 16'h86F7);
    fwd("R3 code zero", 8'hFF, 16'h1234, 0);
    chk("R3 full width", longint'(duty), 16'h1234);
    fwd("R6 level zero", 0, 16'hABCD, 0);
    chk("R6 zero literal", longint'(duty), 0);
    fwd("R6 level max", 8'hFF, 16'h0024, 6);
    chk("R6 max literal", longint'(duty), 16'h9000);
    fwd("R5 odd rounding", 8'h80, 16'h0007, 3);
    for (int i = 0; i < 40; i++) begin
      fwd("R5 random", int'($urandom % 256), int'($urandom % 65536), int'($urandom % 16));
    end

    rb("R10 example", 16'h86F7, 16'h0024, 6, 1'b0, 1'b0);
    rb("R8 fraction on", 16'h86F7, 16'h0024, 6, 1'b1, 1'b0);
    rb("R9 zero period full width", 16'h8000, 16'h0000, 0, 1'b0, 1'b0);
    rb("R9 masked to zero", 16'h5A5A, 16'hFF00, 4, 1'b1, 1'b0);
    rb("R4 readback upper bits", 16'h4321, 16'hF0A5, 8, 1'b0, 1'b0);
    rb("R11 start while busy", 16'h1234, 16'h0FA0, 12, 1'b0, 1'b1);
    for (int i = 0; i < 15; i++) begin
      rb("R10 random", int'($urandom % 65536), int'($urandom % 65536),
         int'($urandom % 16), 1'($urandom % 2), 1'b0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule